// File: doc/BRIEF.md
# Shared-Count Input Debounce Filter

This block cleans up the raw inputs of one general-purpose I/O bank built from four ports of eight pins each. Every pin is first brought into the clock domain by a short synchronizer chain. After that, a pin goes one of two ways. If filtering is off for that pin, the pin is registered straight through. If filtering is on, the pin only changes after its new level has held for a programmed number of millisecond ticks. The filtered vector feeds the bank's input register and its interrupt detector. Those consumers are outside this block, and so is the tick generator.

Each port has a single 8-bit hold-time register, counted in milliseconds. All eight pins of the port share it. Each pin has its own stability counter, so pins on the same port filter independently against the shared limit. Filtering is switched on and off pin by pin through a masked write. That write changes only the enable bits whose mask bits are set, so two agents can update different pins of the same port without a read-modify-write.

Top module: `gpio_dbnc_top`

## Requirements
- R1: After reset release, with the raw inputs held steady, `pin_filt_o` equals `pin_raw_i` within four clock cycles. All filter enables come out of reset at 0.
- R2: A pin whose filter is off follows its raw input with a latency of exactly three clock edges: two synchronizer stages plus one output register.
- R3: A write with `wr_sel_i`=1 targets the enable bits of port `wr_port_i`. Bits 15:8 of `wr_data_i` are the mask and bits 7:0 are the values; bit k of each half maps to pin k of the port. An enable bit whose mask bit is 0 is left as it was, and enables of other ports never change.
- R4: A write with `wr_sel_i`=0 loads `wr_data_i[7:0]` into the hold count of port `wr_port_i`. For an enabled pin with count N>0, a new level reaches the output on the edge of the Nth tick that arrives while the synchronized input differs from the output. It does not reach the output earlier.
- R5: If the synchronized input returns to the output value before the count completes, the pin's stability counter restarts. A later change then needs a full N ticks again.
- R6: An enabled pin on a port whose count is 0 behaves as a pass-through pin (R2 latency).
- R7: All pins of a port use that port's count. Pins on another port use their own port's count.
- R8: Turning one pin's filter off does not alter the port count. The remaining enabled pins of that port keep the same hold time.
- R9: A new count takes effect on the next tick. Counters that are already running are not cleared, so lowering the count below a running counter releases the pin on that next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_ms_i | input | 1 | One-cycle pulse per millisecond |
| pin_raw_i | input | 32 | Raw pin levels, pin index = port*8 + bit |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0: hold count, 1: masked enable write |
| wr_port_i | input | 2 | Target port of the write |
| wr_data_i | input | 16 | Write data (count in 7:0, or mask 15:8 / values 7:0) |
| pin_filt_o | output | 32 | Filtered pin levels |

## Verification
The hardest case to reach from the ports is a stability counter that has already advanced when something external changes under it. One such change is a new, lower count. Another is the input returning to the output value. The stimulus produces both. It lets a fixed number of ticks pass while a pin differs, and only then either writes a smaller count or flips the pin back. The first tick afterwards shows directly whether the partial count was kept or restarted. Per-port sharing is separated by giving two ports different counts and moving pins on both in the same cycle.

// File: rtl/gpio_dbnc_pkg.sv
package gpio_dbnc_pkg;
  typedef enum logic {
    SEL_COUNT  = 1'b0,
    SEL_ENABLE = 1'b1
  } dbnc_sel_e;
endpackage

// File: rtl/gpio_dbnc_sync.sv
module gpio_dbnc_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_dbnc_regs.sv
module gpio_dbnc_regs
  import gpio_dbnc_pkg::*;
#(
  parameter int NP     = 4,
  parameter int PPP    = 8,
  parameter int CNT_W  = 8,
  parameter int PORT_W = 2,
  localparam int DATA_W = 2 * PPP
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                wr_sel_i,
  input  logic [PORT_W-1:0]   wr_port_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic [NP*CNT_W-1:0] cnt_o,
  output logic [NP*PPP-1:0]   en_o
);
  logic [PPP-1:0] wmask, wval;
  logic           sel_en;

  assign wmask  = wr_data_i[DATA_W-1:PPP];
  assign wval   = wr_data_i[PPP-1:0];
  assign sel_en = (dbnc_sel_e'(wr_sel_i) == SEL_ENABLE);

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic [CNT_W-1:0] cnt_q;
    logic [PPP-1:0]   en_q;
    logic             hit;

    assign hit = wr_en_i && (wr_port_i == PORT_W'(p));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
        en_q  <= '0;
      end else if (hit) begin
        if (sel_en) en_q  <= (en_q & ~wmask) | (wval & wmask);
        else        cnt_q <= wr_data_i[CNT_W-1:0];
      end
    end

    assign cnt_o[p*CNT_W +: CNT_W] = cnt_q;
    assign en_o[p*PPP +: PPP]      = en_q;
  end
endmodule

// File: rtl/gpio_dbnc_cell.sv
module gpio_dbnc_cell #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             primed_i,
  input  logic             gate_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tick_i,
  output logic             filt_o
);
  logic [CNT_W-1:0] stab_q;
  logic [CNT_W:0]   stab_nx;
  logic             filt_q;
  logic             bypass;

  assign bypass  = !primed_i || !gate_i;
  assign stab_nx = {1'b0, stab_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b0;
      stab_q <= '0;
    end else if (bypass) begin
      filt_q <= sync_i;
      stab_q <= '0;
    end else if (sync_i == filt_q) begin
      stab_q <= '0;
    end else if (tick_i) begin
      // >= so a count lowered below a running counter releases at once
      if (stab_nx >= {1'b0, cnt_i}) begin
        filt_q <= sync_i;
        stab_q <= '0;
      end else begin
        stab_q <= stab_nx[CNT_W-1:0];
      end
    end
  end

  assign filt_o = filt_q;
endmodule

// File: rtl/gpio_dbnc_top.sv
module gpio_dbnc_top #(
  parameter int NP          = 4,
  parameter int PPP         = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int NPIN   = NP * PPP,
  localparam int PORT_W = (NP > 1) ? $clog2(NP) : 1,
  localparam int DATA_W = 2 * PPP,
  localparam int FILL_W = $clog2(SYNC_STAGES + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_ms_i,
  input  logic [NPIN-1:0]   pin_raw_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [PORT_W-1:0] wr_port_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [NPIN-1:0]   pin_filt_o
);
  logic [NPIN-1:0]     pin_sync;
  logic [NPIN-1:0]     pin_en;
  logic [NPIN-1:0]     pin_gate;
  logic [NP*CNT_W-1:0] cnt_flat;
  logic [FILL_W-1:0]   fill_q;
  logic                primed_q;

  gpio_dbnc_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_raw_i),
    .q_o    (pin_sync)
  );

  // Outputs track the synchronizer until the first real sample has arrived
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q   <= '0;
      primed_q <= 1'b0;
    end else if (!primed_q) begin
      fill_q   <= fill_q + 1'b1;
      primed_q <= (fill_q == FILL_W'(SYNC_STAGES));
    end
  end

  gpio_dbnc_regs #(.NP(NP), .PPP(PPP), .CNT_W(CNT_W), .PORT_W(PORT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_port_i (wr_port_i),
    .wr_data_i (wr_data_i),
    .cnt_o     (cnt_flat),
    .en_o      (pin_en)
  );

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic [CNT_W-1:0] port_cnt;
    assign port_cnt = cnt_flat[p*CNT_W +: CNT_W];

    for (genvar b = 0; b < PPP; b++) begin : g_pin
      localparam int IDX = p * PPP + b;

      assign pin_gate[IDX] = pin_en[IDX] && (port_cnt != '0);

      gpio_dbnc_cell #(.CNT_W(CNT_W)) u_cell (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sync_i   (pin_sync[IDX]),
        .primed_i (primed_q),
        .gate_i   (pin_gate[IDX]),
        .cnt_i    (port_cnt),
        .tick_i   (tick_ms_i),
        .filt_o   (pin_filt_o[IDX])
      );
    end
  end
endmodule

// File: rtl/gpio_dbnc_chk.sv
module gpio_dbnc_chk #(
  parameter int NPIN  = 32,
  parameter int CFW   = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tick_i,
  input logic            wr_en_i,
  input logic            wr_sel_i,
  input logic            primed_i,
  input logic [NPIN-1:0] sync_i,
  input logic [NPIN-1:0] en_i,
  input logic [NPIN-1:0] gate_i,
  input logic [CFW-1:0]  cnt_i,
  input logic [NPIN-1:0] filt_i
);
  AST_DIS_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((filt_i ^ $past(sync_i)) & ~$past(en_i)) == '0); // R2

  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(primed_i) && !$past(tick_i)) |->
      ((filt_i ^ $past(filt_i)) & $past(gate_i)) == '0); // R4

  AST_EN_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i) |-> $stable(en_i)); // R3

  AST_CNT_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i) |-> $stable(cnt_i)); // R4

  AST_CNT_KEPT_ON_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i && wr_sel_i) |-> $stable(cnt_i)); // R8
endmodule

bind gpio_dbnc_top gpio_dbnc_chk #(.NPIN(NPIN), .CFW(NP*CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_ms_i),
  .wr_en_i  (wr_en_i),
  .wr_sel_i (wr_sel_i),
  .primed_i (primed_q),
  .sync_i   (pin_sync),
  .en_i     (pin_en),
  .gate_i   (pin_gate),
  .cnt_i    (cnt_flat),
  .filt_i   (pin_filt_o)
);

// File: tb/gpio_dbnc_top_tb_top.sv
module gpio_dbnc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [31:0] raw = 32'hA5C3_0F96;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [1:0]  wr_port = '0;
  logic [15:0] wr_data = '0;
  logic [31:0] filt;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] model;
  bit done = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  gpio_dbnc_top dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tick_ms_i  (tick),
    .pin_raw_i  (raw),
    .wr_en_i    (wr_en),
    .wr_sel_i   (wr_sel),
    .wr_port_i  (wr_port),
    .wr_data_i  (wr_data),
    .pin_filt_o (filt)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [1:0] port, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_port = port; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  // driver side: update model bits from raw, then queue the expectation
  task automatic expect_upd(input logic [31:0] upd, input string tag);
    model = (model & ~upd) | (raw & upd);
    sb_q.push_back('{exp: model, tag: tag});
  endtask

  // monitor: compares queued items away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_chk++;
        if (filt !== it.exp) begin
          n_fail++;
          $display("FAIL %s: pin_filt_o=%h expected %h", it.tag, filt, it.exp);
        end
      end
    end
  end

  initial begin
    for (int w = 0; w < 20000 && !done; w++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    model = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    expect_upd(32'hFFFF_FFFF, "R1 reset state");

    // R2 pass-through latency
    raw ^= 32'h0000_00FF;
    cyc(2); expect_upd(32'h0, "R2 before 3rd edge");
    cyc(1); expect_upd(32'h0000_00FF, "R2 at 3rd edge");

    // R4 count 3, pins 0-3 enabled; R3 pins 4-7 still pass
    wr(1'b0, 2'd0, 16'h0003);
    wr(1'b1, 2'd0, 16'hFF0F);
    raw ^= 32'h0000_00FF;
    cyc(4); expect_upd(32'h0000_00F0, "R3 unmasked-off pins pass");
    ticks(2); expect_upd(32'h0, "R4 held before Nth tick");
    ticks(1); expect_upd(32'h0000_000F, "R4 released on Nth tick");

    // R3 mask: disable pin0 only; port1 write with zero mask
    wr(1'b1, 2'd0, 16'h0100);
    wr(1'b1, 2'd1, 16'h00FF);
    raw ^= 32'h0000_010F;
    cyc(4); expect_upd(32'h0000_0101, "R3 masked enable write");
    ticks(2); expect_upd(32'h0, "R8 pins1-3 held");
    ticks(1); expect_upd(32'h0000_000E, "R8 count kept after disable");

    // R5 glitch restarts counter
    raw ^= 32'h2;
    cyc(4); ticks(2);
    raw ^= 32'h2;
    cyc(4); expect_upd(32'h0, "R5 glitch suppressed");
    raw ^= 32'h2;
    cyc(4); ticks(2); expect_upd(32'h0, "R5 counter restarted");
    ticks(1); expect_upd(32'h2, "R5 full count after restart");

    // R7 per-port counts
    wr(1'b0, 2'd1, 16'h0001);
    wr(1'b1, 2'd1, 16'hFFFF);
    raw ^= 32'h0000_FE04;
    cyc(4); ticks(1); expect_upd(32'h0000_FE00, "R7 port1 count 1");
    ticks(2); expect_upd(32'h0000_0004, "R7 port0 count 3");

    // R9 lowering count mid-run
    wr(1'b0, 2'd0, 16'h000A);
    raw ^= 32'h8;
    cyc(4); ticks(3); expect_upd(32'h0, "R9 held at count 10");
    wr(1'b0, 2'd0, 16'h0002);
    cyc(1); expect_upd(32'h0, "R9 no change without tick");
    ticks(1); expect_upd(32'h8, "R9 new count on next tick");

    // R6 count 0 with pin enabled
    wr(1'b0, 2'd0, 16'h0000);
    raw ^= 32'h4;
    cyc(2); expect_upd(32'h0, "R6 before 3rd edge");
    cyc(1); expect_upd(32'h4, "R6 zero count passes");

    cyc(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule